// File: doc/BRIEF.md
# Bus width translation sequencer

This block steers a byte-lane data buffer that sits between a bus master and a slave whose data widths may differ. Each request carries a direction, the master width, the slave width and four byte enables. From these the block picks one of three treatments. Equal widths get a plain single cycle. A master narrower than the slave gets a single cycle with a lane copy. A master wider than the slave gets a sequence of narrow slave cycles. For a sequence, the block takes the bus away from the master, runs one slave cycle for each active slave-sized unit of the word, and then hands the bus back.

During a sequence the block drives the buffer controls. These are one latch enable per byte lane, three output-enable groups, a copy enable and a copy direction. A read sequence collects the slave pieces and presents the merged word to the master only on its final cycle. A write sequence captures the master word once and then sends it to the slave one piece at a time. The buffer itself, arbitration and slave wait states are handled elsewhere.

Top module: `bus_width_seq`

## Requirements
- R1: Width codes are 2'b00 = 8-bit, 2'b01 = 16-bit, 2'b10 = 32-bit (2'b11 behaves as 32-bit). When the master and slave widths are equal, an accepted request gives exactly one cycle with slave_cyc=1, slave_lane=0, no latch enable, no output enable, copy_en=0 and busy=0.
- R2: When the master is narrower than the slave, the request gives one cycle with copy_en=1. copy_up is 1 for a write and 0 for a read. busy stays 0 and no latch or output enable is set.
- R3: Active lanes are the byte enables masked by the master width (8-bit: lane 0; 16-bit: lanes 1:0; 32-bit: all four). Units are single lanes for an 8-bit slave, lane pairs {1:0} and {3:2} for a 16-bit slave, or the whole word for a 32-bit slave. A unit is active if any of its lanes is active. When the master is wider than the slave and two to four units are active, the block runs one slave cycle per active unit. busy=1 and slave_cyc=1 on each of these cycles.
- R4: The cycles of a sequence visit active units in ascending order and skip inactive ones. slave_lane gives the lowest byte lane of the current unit.
- R5: In a read sequence, each cycle sets latch_en to the active lanes of the current unit. Only the final cycle drives toward the master: oe_grp[0] is set if lanes 1:0 have any active lane and oe_grp[1] is set if lanes 3:2 have any. oe_grp[2] stays 0.
- R6: In a write sequence, the first cycle sets latch_en to all active lanes and later cycles set none. oe_grp[2] (drive toward the slave) is 1 on every cycle of the sequence and oe_grp[1:0] stay 0.
- R7: In a sequence, copy_en is 1 exactly when the current unit does not start at lane 0. copy_up is then 1 for a read and 0 for a write. copy_up is 0 whenever copy_en is 0.
- R8: When the master is wider than the slave but only one unit is active, the block runs a single cycle without taking the bus. busy=0, no latch or output enable is set, and copy_en and copy_up follow R7.
- R9: The cycle after a sequence's final cycle shows done=1 with busy=0 and slave_cyc=0. done lasts exactly one cycle, and busy never falls without done.
- R10: A request presented while a sequence cycle is showing is ignored. A request presented during the done cycle is accepted and shows its first cycle on the next cycle.
- R11: A request with no active lane after masking by the master width is ignored, and the outputs stay all zero on the following cycle.
- R12: While the synchronous active-high reset is held, all outputs are 0. Every output is registered and shows an accepted request on the cycle after the clock edge that sampled it.
- R13: A 16-bit master accessing an 8-bit slave with both low lanes enabled gets a two-cycle sequence, for reads and for writes alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A cycle request is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mwidth | input | 2 | Master data width code |
| req_swidth | input | 2 | Slave data width code |
| req_be | input | 4 | Byte enables, bit n = lane n |
| slave_cyc | output | 1 | A slave cycle runs this cycle |
| slave_lane | output | 2 | Lowest byte lane of the unit addressed |
| latch_en | output | 4 | Buffer latch enable per byte lane |
| oe_grp | output | 3 | Output enables: [0] master lanes 1:0, [1] master lanes 3:2, [2] toward slave |
| copy_en | output | 1 | Copy between upper and lower lanes this cycle |
| copy_up | output | 1 | Copy direction: 1 = low to high lanes |
| busy | output | 1 | Bus is held by the sequencer |
| done | output | 1 | One-cycle pulse at bus handback |

## Verification
The handback pulse and the acceptance of the next request can fall in the same cycle. The bench provokes this by presenting each new request at once while the done cycle is showing, so that a second sequence or a single cycle must show on the very next cycle, right behind done. The scoreboard judges the whole output vector cycle by cycle. It holds both the done item and the first item of the following request, so a lost, late or duplicated cycle at the seam shows as a mismatch. A request that arrives in the middle of a sequence is judged the same way: the remaining items stay unchanged and an idle item follows done.

// File: rtl/wsq_pkg.sv
package wsq_pkg;

    localparam int LANES     = 4;
    localparam int LANE_IW   = $clog2(LANES);
    localparam int OE_GROUPS = 3;

    localparam logic [OE_GROUPS-1:0] OE_TO_SLAVE = 3'b100;

    typedef enum logic [1:0] {
        WID_8   = 2'b00,
        WID_16  = 2'b01,
        WID_32  = 2'b10,
        WID_RSV = 2'b11
    } wid_e;

    typedef enum logic [1:0] {
        K_NONE,
        K_SINGLE,
        K_SEQ
    } kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ONE,
        S_SEQ,
        S_DONE
    } state_e;

    // Decoded request.
    typedef struct packed {
        kind_e            kind;
        logic             is_write;
        logic [1:0]       s_rank;
        logic [LANES-1:0] lmask;
        logic [LANES-1:0] umask;
        logic             cp_force;
    } plan_t;

    // Registered output vector.
    typedef struct packed {
        logic                 cyc;
        logic [LANE_IW-1:0]   lane;
        logic [LANES-1:0]     latch;
        logic [OE_GROUPS-1:0] oe;
        logic                 cp_en;
        logic                 cp_up;
        logic                 busy;
        logic                 done;
    } outv_t;

    function automatic logic [1:0] width_rank(input logic [1:0] code);
        case (code)
            WID_8:   return 2'd0;
            WID_16:  return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    function automatic logic [LANES-1:0] master_lanes(input logic [1:0] rank);
        case (rank)
            2'd0:    return 4'b0001;
            2'd1:    return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [LANES-1:0] unit_lanes(input logic [1:0] rank,
                                                    input logic [LANE_IW-1:0] base);
        case (rank)
            2'd0:    return 4'b0001 << base;
            2'd1:    return 4'b0011 << base;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic int unsigned count_units(input logic [LANES-1:0] m);
        int unsigned c;
        c = 0;
        for (int i = 0; i < LANES; i++) begin
            c += m[i] ? 1 : 0;
        end
        return c;
    endfunction

endpackage

// File: rtl/wsq_decode.sv
module wsq_decode
    import wsq_pkg::*;
(
    input  logic             is_write,
    input  logic [1:0]       m_code,
    input  logic [1:0]       s_code,
    input  logic [LANES-1:0] be,
    output plan_t            plan
);
    logic [1:0]       m_rank;
    logic [1:0]       s_rank;
    logic [LANES-1:0] lm;
    logic [LANES-1:0] um;

    always_comb begin
        m_rank = width_rank(m_code);
        s_rank = width_rank(s_code);
        lm     = be & master_lanes(m_rank);
        case (s_rank)
            2'd0:    um = lm;
            2'd1:    um = {1'b0, |lm[3:2], 1'b0, |lm[1:0]};
            default: um = {3'b000, |lm};
        endcase

        plan.is_write = is_write;
        plan.s_rank   = s_rank;
        plan.lmask    = lm;
        plan.umask    = um;
        plan.cp_force = (m_rank < s_rank);
        if (lm == '0) begin
            plan.kind = K_NONE;
        end else if ((m_rank > s_rank) && (count_units(um) >= 2)) begin
            plan.kind = K_SEQ;
        end else begin
            plan.kind = K_SINGLE;
        end
    end
endmodule

// File: rtl/wsq_pick.sv
module wsq_pick #(
    parameter  int N  = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  mask,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  rest
);
    logic [N:0]   seen;
    logic [N-1:0] hot;

    assign seen[0] = 1'b0;

    generate
        for (genvar g = 0; g < N; g++) begin : g_scan
            assign seen[g+1] = seen[g] | mask[g];
            assign hot[g]    = mask[g] & ~seen[g];
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hot[i]) begin
                idx = i[IW-1:0];
            end
        end
    end

    assign rest = mask & ~hot;
endmodule

// File: rtl/wsq_drive.sv
module wsq_drive
    import wsq_pkg::*;
(
    input  plan_t                pl,
    input  logic [LANE_IW-1:0]   base,
    input  logic                 seq,
    input  logic                 first,
    input  logic                 last,
    output logic [LANES-1:0]     latch,
    output logic [OE_GROUPS-1:0] oe,
    output logic                 cp_en,
    output logic                 cp_up
);
    logic [LANES-1:0] ul;

    always_comb begin
        ul    = unit_lanes(pl.s_rank, base) & pl.lmask;
        latch = '0;
        oe    = '0;
        cp_en = 1'b0;
        cp_up = 1'b0;
        if (seq) begin
            cp_en = (base != '0);
            cp_up = cp_en & ~pl.is_write;
            if (pl.is_write) begin
                latch = first ? pl.lmask : '0;
                oe    = OE_TO_SLAVE;
            end else begin
                latch = ul;
                if (last) begin
                    oe = {1'b0, |pl.lmask[3:2], |pl.lmask[1:0]};
                end
            end
        end else if (pl.cp_force) begin
            cp_en = 1'b1;
            cp_up = pl.is_write;
        end else begin
            cp_en = (base != '0);
            cp_up = cp_en & ~pl.is_write;
        end
    end
endmodule

// File: rtl/bus_width_seq.sv
module bus_width_seq
    import wsq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [1:0]           req_mwidth,
    input  logic [1:0]           req_swidth,
    input  logic [LANES-1:0]     req_be,
    output logic                 slave_cyc,
    output logic [LANE_IW-1:0]   slave_lane,
    output logic [LANES-1:0]     latch_en,
    output logic [OE_GROUPS-1:0] oe_grp,
    output logic                 copy_en,
    output logic                 copy_up,
    output logic                 busy,
    output logic                 done
);
    state_e           st_q, st_d;
    plan_t            plan_q, plan_d, dec_plan, use_plan;
    logic [LANES-1:0] rem_q, rem_d, pick_src, pick_rest;
    outv_t            out_q, out_d;

    logic [LANE_IW-1:0]   pick_idx;
    logic                 seq_more;
    logic                 drv_seq;
    logic [LANES-1:0]     drv_latch;
    logic [OE_GROUPS-1:0] drv_oe;
    logic                 drv_cp_en;
    logic                 drv_cp_up;

    wsq_decode u_dec (
        .is_write (req_write),
        .m_code   (req_mwidth),
        .s_code   (req_swidth),
        .be       (req_be),
        .plan     (dec_plan)
    );

    assign seq_more = (st_q == S_SEQ) && (rem_q != '0);
    assign use_plan = seq_more ? plan_q : dec_plan;
    assign pick_src = seq_more ? rem_q : dec_plan.umask;
    assign drv_seq  = seq_more || (dec_plan.kind == K_SEQ);

    wsq_pick #(.N(LANES)) u_pick (
        .mask (pick_src),
        .idx  (pick_idx),
        .rest (pick_rest)
    );

    wsq_drive u_drv (
        .pl    (use_plan),
        .base  (pick_idx),
        .seq   (drv_seq),
        .first (!seq_more),
        .last  (pick_rest == '0),
        .latch (drv_latch),
        .oe    (drv_oe),
        .cp_en (drv_cp_en),
        .cp_up (drv_cp_up)
    );

    always_comb begin
        st_d   = S_IDLE;
        plan_d = plan_q;
        rem_d  = rem_q;
        out_d  = '0;
        if (st_q == S_SEQ) begin
            if (rem_q != '0) begin
                out_d.cyc   = 1'b1;
                out_d.lane  = pick_idx;
                out_d.latch = drv_latch;
                out_d.oe    = drv_oe;
                out_d.cp_en = drv_cp_en;
                out_d.cp_up = drv_cp_up;
                out_d.busy  = 1'b1;
                rem_d       = pick_rest;
                st_d        = S_SEQ;
            end else begin
                out_d.done = 1'b1;
                st_d       = S_DONE;
            end
        end else if (req_valid && (dec_plan.kind != K_NONE)) begin
            out_d.cyc   = 1'b1;
            out_d.lane  = pick_idx;
            out_d.latch = drv_latch;
            out_d.oe    = drv_oe;
            out_d.cp_en = drv_cp_en;
            out_d.cp_up = drv_cp_up;
            if (dec_plan.kind == K_SEQ) begin
                out_d.busy = 1'b1;
                plan_d     = dec_plan;
                rem_d      = pick_rest;
                st_d       = S_SEQ;
            end else begin
                st_d = S_ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            plan_q <= '0;
            rem_q  <= '0;
            out_q  <= '0;
        end else begin
            st_q   <= st_d;
            plan_q <= plan_d;
            rem_q  <= rem_d;
            out_q  <= out_d;
        end
    end

    assign slave_cyc  = out_q.cyc;
    assign slave_lane = out_q.lane;
    assign latch_en   = out_q.latch;
    assign oe_grp     = out_q.oe;
    assign copy_en    = out_q.cp_en;
    assign copy_up    = out_q.cp_up;
    assign busy       = out_q.busy;
    assign done       = out_q.done;
endmodule

// File: rtl/wsq_check.sv
module wsq_check
    import wsq_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 slave_cyc,
    input logic [LANE_IW-1:0]   slave_lane,
    input logic [LANES-1:0]     latch_en,
    input logic [OE_GROUPS-1:0] oe_grp,
    input logic                 copy_en,
    input logic                 copy_up,
    input logic                 busy,
    input logic                 done
);
    assert_busy_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        busy |-> slave_cyc);

    assert_lane_order_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (slave_lane > $past(slave_lane)));

    assert_slave_side_R6: assert property (@(posedge clk) disable iff (rst)
        oe_grp[2] |-> (busy && (oe_grp[1:0] == 2'b00)));

    assert_dir_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !copy_en |-> !copy_up);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_handback_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!slave_cyc && !busy));

    assert_no_stray_R12: assert property (@(posedge clk) disable iff (rst)
        !slave_cyc |-> ((latch_en == '0) && (oe_grp == '0) && !copy_en));
endmodule

bind bus_width_seq wsq_check u_chk (
    .clk        (clk),
    .rst        (rst),
    .slave_cyc  (slave_cyc),
    .slave_lane (slave_lane),
    .latch_en   (latch_en),
    .oe_grp     (oe_grp),
    .copy_en    (copy_en),
    .copy_up    (copy_up),
    .busy       (busy),
    .done       (done)
);

// File: tb/sim_bus_width_seq.sv
`timescale 1ns/1ps
module sim_bus_width_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [1:0] req_mwidth = 2'b00;
    logic [1:0] req_swidth = 2'b00;
    logic [3:0] req_be = 4'b0000;
    logic       slave_cyc, copy_en, copy_up, busy, done;
    logic [1:0] slave_lane;
    logic [3:0] latch_en;
    logic [2:0] oe_grp;
    logic [13:0] got;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    logic [13:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    bus_width_seq u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_mwidth(req_mwidth), .req_swidth(req_swidth), .req_be(req_be),
        .slave_cyc(slave_cyc), .slave_lane(slave_lane), .latch_en(latch_en),
        .oe_grp(oe_grp), .copy_en(copy_en), .copy_up(copy_up),
        .busy(busy), .done(done)
    );

    assign got = {slave_cyc, slave_lane, latch_en, oe_grp, copy_en, copy_up, busy, done};

    function automatic int rank_of(input logic [1:0] c);
        return (c == 2'b00) ? 0 : (c == 2'b01) ? 1 : 2;
    endfunction

    task automatic push_exp(input logic [13:0] v, input string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    // Expected cycle items of one request, built from the requirements.
    task automatic plan_exp(input logic w, input logic [1:0] mw, input logic [1:0] sw,
                            input logic [3:0] be, input string t, output int n);
        int rm, rs, nb;
        logic [3:0] lm, lanes, lat;
        logic [2:0] oe;
        logic [1:0] bl;
        logic cpe, cpu;
        int bases[$];
        rm = rank_of(mw);
        rs = rank_of(sw);
        lm = be & ((rm == 0) ? 4'h1 : (rm == 1) ? 4'h3 : 4'hF);
        for (int k = 0; k < 4; k++) begin
            if (rs == 0 && lm[k]) bases.push_back(k);
            if (rs == 1 && (k == 0 || k == 2)) begin
                if (lm[k] || lm[k+1]) bases.push_back(k);
            end
            if (rs == 2 && k == 0 && lm != 4'h0) bases.push_back(k);
        end
        nb = bases.size();
        if (lm == 4'h0) begin
            push_exp(14'h0, t);
            n = 1;
        end else if (rm > rs && nb >= 2) begin
            for (int i = 0; i < nb; i++) begin
                bl    = bases[i][1:0];
                lanes = ((rs == 0) ? (4'b0001 << bl) : (4'b0011 << bl)) & lm;
                cpe   = (bl != 2'b00);
                cpu   = cpe && !w;
                if (w) begin
                    lat = (i == 0) ? lm : 4'h0;
                    oe  = 3'b100;
                end else begin
                    lat = lanes;
                    oe  = (i == nb - 1) ? {1'b0, |lm[3:2], |lm[1:0]} : 3'b000;
                end
                push_exp({1'b1, bl, lat, oe, cpe, cpu, 1'b1, 1'b0}, t);
            end
            push_exp(14'h0001, {t, " R9"});
            n = nb + 1;
        end else begin
            bl = bases[0][1:0];
            if (rm < rs) begin
                cpe = 1'b1;
                cpu = w;
            end else begin
                cpe = (bl != 2'b00);
                cpu = cpe && !w;
            end
            push_exp({1'b1, bl, 4'h0, 3'b000, cpe, cpu, 1'b0, 1'b0}, t);
            n = 1;
        end
    endtask

    task automatic drive_req(input logic w, input logic [1:0] mw, input logic [1:0] sw,
                             input logic [3:0] be);
        req_valid  = 1'b1;
        req_write  = w;
        req_mwidth = mw;
        req_swidth = sw;
        req_be     = be;
    endtask

    // Called just after a falling edge; returns just after the falling edge
    // of the request's last expected item.
    task automatic issue(input logic w, input logic [1:0] mw, input logic [1:0] sw,
                         input logic [3:0] be, input string t);
        int n;
        plan_exp(w, mw, sw, be, t, n);
        drive_req(w, mw, sw, be);
        @(negedge clk); #1;
        req_valid = 1'b0;
        repeat (n - 1) begin
            @(negedge clk); #1;
        end
    endtask

    // A sequence with a second request arriving during its first cycle.
    task automatic issue_intrude(input logic w, input logic [1:0] mw, input logic [1:0] sw,
                                 input logic [3:0] be, input string t);
        int n;
        plan_exp(w, mw, sw, be, t, n);
        drive_req(w, mw, sw, be);
        @(negedge clk); #1;
        drive_req(1'b0, 2'b10, 2'b10, 4'hF);
        @(negedge clk); #1;
        req_valid = 1'b0;
        repeat (n - 2) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic idle_cycle(input string t);
        push_exp(14'h0, t);
        @(negedge clk); #1;
    endtask

    always @(negedge clk) begin
        if (!rst && exp_q.size() > 0) begin
            logic [13:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (got !== e) begin
                fails++;
                $display("FAIL %s: got %h expected %h", t, got, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): got hang expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (got !== 14'h0) begin
            fails++;
            $display("FAIL R12 reset: got %h expected %h", got, 14'h0);
        end
        @(negedge clk); #1;
        rst = 1'b0;
        @(negedge clk); #1;

        // R1 pass-through
        issue(1'b0, 2'b10, 2'b10, 4'hF, "R1 32/32 read");
        issue(1'b1, 2'b00, 2'b00, 4'h1, "R1 8/8 write");
        issue(1'b1, 2'b11, 2'b10, 4'h3, "R1 reserved code as 32");
        idle_cycle("R12 idle");
        // R2 narrow master
        issue(1'b1, 2'b01, 2'b10, 4'h3, "R2 16/32 write");
        issue(1'b0, 2'b00, 2'b01, 4'h1, "R2 8/16 read");
        // R3 R5 R7 assembly, then R10 back-to-back during done
        issue(1'b0, 2'b10, 2'b00, 4'hF, "R3 R5 R7 asm 32/8");
        issue(1'b0, 2'b10, 2'b01, 4'hF, "R10 R5 asm 32/16 after done");
        issue(1'b1, 2'b10, 2'b00, 4'hA, "R4 R6 dis 32/8 skip lanes");
        issue(1'b1, 2'b10, 2'b01, 4'h6, "R6 R7 dis 32/16");
        issue(1'b0, 2'b10, 2'b00, 4'hC, "R4 R5 asm high lanes");
        idle_cycle("R9 idle after done");
        // R13 16-bit master on 8-bit slave
        issue(1'b1, 2'b01, 2'b00, 4'h3, "R13 dis 16/8");
        issue(1'b0, 2'b01, 2'b00, 4'h3, "R13 asm 16/8");
        // R8 single mismatch
        issue(1'b0, 2'b10, 2'b00, 4'h4, "R8 32/8 one unit read");
        issue(1'b1, 2'b10, 2'b01, 4'hC, "R8 32/16 one unit write");
        issue(1'b0, 2'b10, 2'b01, 4'h1, "R8 32/16 base unit");
        // R11 empty enables
        issue(1'b0, 2'b10, 2'b00, 4'h0, "R11 no enables");
        issue(1'b1, 2'b00, 2'b01, 4'hE, "R11 masked to none");
        // R10 request mid-sequence ignored
        issue_intrude(1'b0, 2'b10, 2'b00, 4'h7, "R10 intruder ignored");
        idle_cycle("R10 no late start");
        idle_cycle("R12 idle end");

        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule